// File: doc/BRIEF.md
# Dual-Unit Status Word Write Merger

This block retires, in one clock cycle, a small batch of masked register writes that two execution units produced in the same issue slot. Each write record names a target (the 32-bit processor status word or one of a small set of general registers), carries a bit mask and a value, and is merged into the target so that only the masked bits change. Records are applied in queue order, lowest index first. The merged state is held in registers and presented on the outputs.

When two records in the same batch both write arithmetic flag bits of the status word, the later record wins: the bits it shares with the earlier record are removed from the earlier record's mask. A later write of the overflow flag also removes the accumulated-overflow flag from the earlier record, because the later unit only sets accumulated overflow when an overflow actually occurred. This contention handling is switched off when the memory-side unit's operation was a move to a system register. After the writes, an ordinary trap or a debug trap clears the status word down to a small set of preserved bits.

Top module: `sw_write_merge`

## Requirements
- R1: While reset is asserted, and right after it is released, the status word and every general register read zero.
- R2: On a cycle with the commit strobe high, each record whose valid bit is high updates its target as (old AND NOT mask) OR (value AND mask); records are applied from index 0 upwards, so a later record's masked bits overwrite an earlier one's, and records with the valid bit low change nothing.
- R3: Status bits are numbered from the most significant end (bit n has weight 2^(31-n)). The flag set is F0=17, F1=19, F2=21, F3=23, S=25, V=27, VA=29, C=31. When a later valid status record's mask shares flag bits with an earlier valid status record's flag bits, those shared bits are removed from the earlier record's mask; non-flag bits of the earlier record still apply.
- R4: When such an overlap exists and the later record's mask includes V (bit 27), VA (bit 29) is also removed from the earlier record's mask; without any flag overlap, VA is not removed.
- R5: With the exemption input high, no mask is trimmed and every status record applies its full mask in order.
- R6: An ordinary trap in the commit cycle leaves the status word, after the writes, with only SM (bit 0) and DB (bit 3) kept and every other bit cleared.
- R7: A debug trap in the commit cycle clears every status bit except DS (bit 5) and then sets DS; when both traps are raised, the ordinary trap is applied instead.
- R8: A record with the target-is-status bit low writes general register number idx with the plain masked merge, takes no part in flag contention, and never trims or is trimmed.
- R9: On a cycle with the commit strobe low, the status word and all general registers keep their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| commit_i | input | 1 | Apply the batch this cycle |
| rec_vld_i | input | NREC | Valid bit per record |
| rec_sw_i | input | NREC | Record targets the status word when high |
| rec_idx_i | input | NREC*IDX_W | General register number per record |
| rec_mask_i | input | NREC*32 | Bit mask per record |
| rec_val_i | input | NREC*32 | Write value per record |
| exempt_i | input | 1 | Memory-side op was a move to system register: skip contention |
| trap_ord_i | input | 1 | Ordinary trap after the writes |
| trap_dbg_i | input | 1 | Debug trap after the writes |
| sw_o | output | 32 | Status word |
| regs_o | output | NREG*32 | General registers, register 0 in the low word |

## Verification
The bench builds the block with its defaults, four records and four general registers, so every pairwise and three-way ordering of status and register records in a batch occurs. A long sweep draws masks biased toward the flag set together with exemption and trap inputs, and compares the whole register state against an arithmetic model after every batch. Directed batches pin the overflow-to-accumulated-overflow inference, the no-overlap case where it must not fire, both trap kinds and their priority, and idle cycles with busy inputs.

// File: rtl/swm_pkg.sv
package swm_pkg;

  localparam int WORD_W = 32;

  // Status bit positions, counted from the most significant bit.
  localparam int P_SM = 0;
  localparam int P_DB = 3;
  localparam int P_DS = 5;
  localparam int P_F0 = 17;
  localparam int P_F1 = 19;
  localparam int P_F2 = 21;
  localparam int P_F3 = 23;
  localparam int P_S  = 25;
  localparam int P_V  = 27;
  localparam int P_VA = 29;
  localparam int P_C  = 31;

  localparam logic [WORD_W-1:0] TOP_BIT = 32'h8000_0000;

  localparam logic [WORD_W-1:0] SM_BIT = TOP_BIT >> P_SM;
  localparam logic [WORD_W-1:0] DB_BIT = TOP_BIT >> P_DB;
  localparam logic [WORD_W-1:0] DS_BIT = TOP_BIT >> P_DS;
  localparam logic [WORD_W-1:0] V_BIT  = TOP_BIT >> P_V;
  localparam logic [WORD_W-1:0] VA_BIT = TOP_BIT >> P_VA;

  localparam logic [WORD_W-1:0] FLAG_SET =
      (TOP_BIT >> P_F0) | (TOP_BIT >> P_F1) | (TOP_BIT >> P_F2) |
      (TOP_BIT >> P_F3) | (TOP_BIT >> P_S)  | V_BIT | VA_BIT |
      (TOP_BIT >> P_C);

  localparam logic [WORD_W-1:0] ORD_KEEP = SM_BIT | DB_BIT;

endpackage

// File: rtl/swm_contend.sv
module swm_contend
  import swm_pkg::*;
#(
  parameter int NREC = 4
) (
  input  logic [NREC-1:0]        vld_i,
  input  logic [NREC-1:0]        sw_i,
  input  logic [NREC*WORD_W-1:0] mask_i,
  input  logic                   exempt_i,
  output logic [NREC*WORD_W-1:0] eff_o
);

  for (genvar gi = 0; gi < NREC; gi++) begin : g_rec
    logic [WORD_W-1:0] own;
    logic [WORD_W-1:0] mine;
    logic [WORD_W-1:0] trim;

    always_comb begin
      own  = mask_i[gi*WORD_W +: WORD_W];
      mine = own & FLAG_SET;
      trim = own;
      if (!exempt_i && vld_i[gi] && sw_i[gi]) begin
        for (int j = gi + 1; j < NREC; j++) begin
          if (vld_i[j] && sw_i[j] &&
              ((mask_i[j*WORD_W +: WORD_W] & mine) != '0)) begin
            trim = trim & ~(mask_i[j*WORD_W +: WORD_W] & mine);
            if ((mask_i[j*WORD_W +: WORD_W] & V_BIT) != '0) begin
              trim = trim & ~VA_BIT;
            end
          end
        end
      end
    end

    assign eff_o[gi*WORD_W +: WORD_W] = trim;

    always_comb begin
      AST_TRIM_SUBSET: assert ((eff_o[gi*WORD_W +: WORD_W] & ~mask_i[gi*WORD_W +: WORD_W]) == '0); // R3
      if (exempt_i) begin
        AST_EXEMPT_FULL_MASK: assert (eff_o[gi*WORD_W +: WORD_W] == mask_i[gi*WORD_W +: WORD_W]); // R5
      end
      if (!sw_i[gi]) begin
        AST_REG_UNTRIMMED: assert (eff_o[gi*WORD_W +: WORD_W] == mask_i[gi*WORD_W +: WORD_W]); // R8
      end
    end
  end

endmodule

// File: rtl/swm_apply.sv
module swm_apply
  import swm_pkg::*;
#(
  parameter int NREC  = 4,
  parameter int NREG  = 4,
  parameter int IDX_W = 2
) (
  input  logic [WORD_W-1:0]      sw_old_i,
  input  logic [NREG*WORD_W-1:0] rg_old_i,
  input  logic [NREC-1:0]        vld_i,
  input  logic [NREC-1:0]        sw_i,
  input  logic [NREC*IDX_W-1:0]  idx_i,
  input  logic [NREC*WORD_W-1:0] mask_i,
  input  logic [NREC*WORD_W-1:0] val_i,
  output logic [WORD_W-1:0]      sw_new_o,
  output logic [NREG*WORD_W-1:0] rg_new_o
);

  logic [WORD_W-1:0]      sw_t;
  logic [NREG*WORD_W-1:0] rg_t;
  logic [WORD_W-1:0]      m;
  logic [WORD_W-1:0]      v;

  always_comb begin
    sw_t = sw_old_i;
    rg_t = rg_old_i;
    m    = '0;
    v    = '0;
    for (int i = 0; i < NREC; i++) begin
      m = mask_i[i*WORD_W +: WORD_W];
      v = val_i[i*WORD_W +: WORD_W];
      if (vld_i[i]) begin
        if (sw_i[i]) begin
          sw_t = (sw_t & ~m) | (v & m);
        end else begin
          for (int r = 0; r < NREG; r++) begin
            if (idx_i[i*IDX_W +: IDX_W] == IDX_W'(r)) begin
              rg_t[r*WORD_W +: WORD_W] =
                  (rg_t[r*WORD_W +: WORD_W] & ~m) | (v & m);
            end
          end
        end
      end
    end
  end

  assign sw_new_o = sw_t;
  assign rg_new_o = rg_t;

endmodule

// File: rtl/swm_trap.sv
module swm_trap
  import swm_pkg::*;
(
  input  logic [WORD_W-1:0] sw_i,
  input  logic              ord_i,
  input  logic              dbg_i,
  output logic [WORD_W-1:0] sw_o
);

  always_comb begin
    if (ord_i) begin
      sw_o = sw_i & ORD_KEEP;
    end else if (dbg_i) begin
      sw_o = (sw_i & DS_BIT) | DS_BIT;
    end else begin
      sw_o = sw_i;
    end
  end

endmodule

// File: rtl/sw_write_merge.sv
module sw_write_merge
  import swm_pkg::*;
#(
  parameter int NREC  = 4,
  parameter int NREG  = 4,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit_i,
  input  logic [NREC-1:0]        rec_vld_i,
  input  logic [NREC-1:0]        rec_sw_i,
  input  logic [NREC*IDX_W-1:0]  rec_idx_i,
  input  logic [NREC*WORD_W-1:0] rec_mask_i,
  input  logic [NREC*WORD_W-1:0] rec_val_i,
  input  logic                   exempt_i,
  input  logic                   trap_ord_i,
  input  logic                   trap_dbg_i,
  output logic [WORD_W-1:0]      sw_o,
  output logic [NREG*WORD_W-1:0] regs_o
);

  localparam int RG_W = NREG * WORD_W;

  logic [WORD_W-1:0]      sw_q,  sw_d;
  logic [RG_W-1:0]        rg_q,  rg_d;
  logic [NREC*WORD_W-1:0] eff_mask;
  logic [WORD_W-1:0]      sw_merged;
  logic [RG_W-1:0]        rg_merged;
  logic [WORD_W-1:0]      sw_trapped;

  swm_contend #(.NREC(NREC)) i_contend (
    .vld_i    (rec_vld_i),
    .sw_i     (rec_sw_i),
    .mask_i   (rec_mask_i),
    .exempt_i (exempt_i),
    .eff_o    (eff_mask)
  );

  swm_apply #(.NREC(NREC), .NREG(NREG), .IDX_W(IDX_W)) i_apply (
    .sw_old_i (sw_q),
    .rg_old_i (rg_q),
    .vld_i    (rec_vld_i),
    .sw_i     (rec_sw_i),
    .idx_i    (rec_idx_i),
    .mask_i   (eff_mask),
    .val_i    (rec_val_i),
    .sw_new_o (sw_merged),
    .rg_new_o (rg_merged)
  );

  swm_trap i_trap (
    .sw_i  (sw_merged),
    .ord_i (trap_ord_i),
    .dbg_i (trap_dbg_i),
    .sw_o  (sw_trapped)
  );

  // Next state: clock enable is the commit strobe.
  always_comb begin
    sw_d = sw_q;
    rg_d = rg_q;
    if (commit_i) begin
      sw_d = sw_trapped;
      rg_d = rg_merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q <= '0;
      rg_q <= '0;
    end else begin
      sw_q <= sw_d;
      rg_q <= rg_d;
    end
  end

  assign sw_o   = sw_q;
  assign regs_o = rg_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> ($stable(sw_o) && $stable(regs_o))); // R9

  AST_ORD_TRAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && trap_ord_i) |=> ((sw_o & ~ORD_KEEP) == '0)); // R6

  AST_DBG_TRAP_DS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && trap_dbg_i && !trap_ord_i) |=> (sw_o == DS_BIT)); // R7

  AST_REGS_UNTOUCHED_BY_SW: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && ((rec_vld_i & ~rec_sw_i) == '0)) |=> $stable(regs_o)); // R8

endmodule

// File: tb/test_sw_write_merge.sv
module test_sw_write_merge;

  localparam int CLK_PERIOD = 10;
  localparam int NREC  = 4;
  localparam int NREG  = 4;
  localparam int IDX_W = 2;
  localparam int W     = 32;

  localparam logic [31:0] B_SM = 32'h8000_0000 >> 0;
  localparam logic [31:0] B_DB = 32'h8000_0000 >> 3;
  localparam logic [31:0] B_DS = 32'h8000_0000 >> 5;
  localparam logic [31:0] B_F0 = 32'h8000_0000 >> 17;
  localparam logic [31:0] B_F1 = 32'h8000_0000 >> 19;
  localparam logic [31:0] B_V  = 32'h8000_0000 >> 27;
  localparam logic [31:0] B_VA = 32'h8000_0000 >> 29;
  localparam logic [31:0] FLAGS = (32'h8000_0000 >> 17) | (32'h8000_0000 >> 19) |
      (32'h8000_0000 >> 21) | (32'h8000_0000 >> 23) | (32'h8000_0000 >> 25) |
      (32'h8000_0000 >> 27) | (32'h8000_0000 >> 29) | (32'h8000_0000 >> 31);

  logic clk = 1'b0;
  logic rst_n;
  logic commit;
  logic [NREC-1:0]       vld, tsw;
  logic [NREC*IDX_W-1:0] idx;
  logic [NREC*W-1:0]     msk, val;
  logic exempt, tord, tdbg;
  logic [W-1:0]          sw_o;
  logic [NREG*W-1:0]     regs_o;

  logic [W-1:0] exp_sw;
  logic [W-1:0] exp_rg [NREG];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sw_write_merge #(.NREC(NREC), .NREG(NREG), .IDX_W(IDX_W)) i_sw_write_merge (
    .clk(clk), .rst_n(rst_n), .commit_i(commit),
    .rec_vld_i(vld), .rec_sw_i(tsw), .rec_idx_i(idx),
    .rec_mask_i(msk), .rec_val_i(val),
    .exempt_i(exempt), .trap_ord_i(tord), .trap_dbg_i(tdbg),
    .sw_o(sw_o), .regs_o(regs_o)
  );

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    logic ok;
    ok = (sw_o === exp_sw);
    for (int r = 0; r < NREG; r++) if (regs_o[r*W +: W] !== exp_rg[r]) ok = 1'b0;
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual sw=%08h r0=%08h r1=%08h r2=%08h r3=%08h expected sw=%08h r0=%08h r1=%08h r2=%08h r3=%08h",
               tag, sw_o, regs_o[31:0], regs_o[63:32], regs_o[95:64], regs_o[127:96],
               exp_sw, exp_rg[0], exp_rg[1], exp_rg[2], exp_rg[3]);
    end
  endtask

  // Reference from the requirements: trim (R3, R4, R5), apply (R2, R8), trap (R6, R7).
  task automatic model();
    logic [W-1:0] em [NREC];
    logic [W-1:0] mi, mj, ov, m, v;
    for (int i = 0; i < NREC; i++) begin
      em[i] = msk[i*W +: W];
      mi = em[i] & FLAGS;
      if (!exempt && vld[i] && tsw[i]) begin
        for (int j = i + 1; j < NREC; j++) begin
          mj = msk[j*W +: W];
          ov = mj & mi;
          if (vld[j] && tsw[j] && ov != 0) begin
            em[i] &= ~ov;
            if ((mj & B_V) != 0) em[i] &= ~B_VA;
          end
        end
      end
    end
    for (int i = 0; i < NREC; i++) begin
      m = em[i];
      v = val[i*W +: W];
      if (vld[i]) begin
        if (tsw[i]) exp_sw = (exp_sw & ~m) | (v & m);
        else exp_rg[idx[i*IDX_W +: IDX_W]] = (exp_rg[idx[i*IDX_W +: IDX_W]] & ~m) | (v & m);
      end
    end
    if (tord) exp_sw = exp_sw & (B_SM | B_DB);
    else if (tdbg) exp_sw = B_DS;
  endtask

  task automatic clear_in();
    vld = '0; tsw = '0; idx = '0; msk = '0; val = '0;
    exempt = 0; tord = 0; tdbg = 0;
  endtask

  task automatic set_rec(input int i, input logic s, input int r,
                         input logic [31:0] m, input logic [31:0] v);
    vld[i] = 1'b1; tsw[i] = s; idx[i*IDX_W +: IDX_W] = IDX_W'(r);
    msk[i*W +: W] = m; val[i*W +: W] = v;
  endtask

  // Inputs set at a falling edge, captured at the next rising edge, checked one fall later.
  task automatic run_commit(input string tag);
    model();
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    check_state(tag);
  endtask

  function automatic logic [31:0] rnd_mask();
    logic [31:0] m;
    m = $urandom;
    case ($urandom % 4)
      0: m = m & FLAGS;
      1: m = m & (FLAGS | B_DS | B_SM);
      2: m = m | B_V;
      default: ;
    endcase
    return m;
  endfunction

  initial begin
    rst_n = 1'b0;
    commit = 1'b0;
    clear_in();
    exp_sw = '0;
    for (int r = 0; r < NREG; r++) exp_rg[r] = '0;
    repeat (3) @(negedge clk);
    check_state("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 after reset");

    // R2: in-order masked merge to one general register, later record wins
    clear_in();
    set_rec(0, 0, 1, 32'h0000_ffff, 32'h0000_1234);
    set_rec(1, 0, 1, 32'h0000_00ff, 32'h0000_00ab);
    set_rec(2, 0, 1, 32'hffff_0000, 32'hcafe_0000);
    vld[2] = 1'b0;
    run_commit("R2 ordered merge");
    check32("R2 literal reg1", regs_o[63:32], 32'h0000_12ab);

    // R4: V in later mask suppresses earlier VA
    clear_in();
    set_rec(0, 1, 0, B_V | B_VA, B_V | B_VA);
    set_rec(1, 1, 0, B_V, 32'h0);
    run_commit("R4 V implies VA suppression");
    check32("R4 literal sw", sw_o, 32'h0);

    // R5: same batch with exemption applies full masks
    exempt = 1'b1;
    run_commit("R5 exemption");
    check32("R5 literal sw", sw_o, B_VA);

    // R4: no flag overlap -> VA of earlier record kept
    clear_in();
    set_rec(0, 1, 0, B_VA, 32'h0);
    run_commit("R4 clear VA");
    clear_in();
    set_rec(0, 1, 0, B_VA, B_VA);
    set_rec(2, 1, 0, B_V, B_V);
    run_commit("R4 no overlap");
    check32("R4 literal no overlap", sw_o, B_V | B_VA);

    // R3: shared flag removed, non-flag bit still applied
    clear_in();
    set_rec(0, 1, 0, 32'hffff_ffff, 32'h0);
    run_commit("R3 clear");
    clear_in();
    set_rec(0, 1, 0, B_F0 | B_F1 | (32'h8000_0000 >> 10), 32'hffff_ffff);
    set_rec(3, 1, 0, B_F1, 32'h0);
    run_commit("R3 partial overlap");
    check32("R3 literal sw", sw_o, B_F0 | (32'h8000_0000 >> 10));

    // R8: register record beside status records, no trimming either way
    clear_in();
    set_rec(0, 0, 2, 32'hffff_ffff, 32'h1357_9bdf);
    set_rec(1, 1, 0, 32'hffff_ffff, 32'h5a5a_5a5a);
    set_rec(2, 0, 3, FLAGS, 32'hffff_ffff);
    run_commit("R8 register records");
    check32("R8 literal reg2", regs_o[95:64], 32'h1357_9bdf);
    check32("R8 literal reg3", regs_o[127:96], FLAGS);

    // R6: ordinary trap
    clear_in();
    set_rec(0, 1, 0, 32'hffff_ffff, 32'hffff_ffff);
    tord = 1'b1;
    run_commit("R6 ordinary trap");
    check32("R6 literal sw", sw_o, B_SM | B_DB);

    // R7: debug trap, then both traps
    clear_in();
    set_rec(0, 1, 0, 32'hffff_ffff, 32'hffff_ffff);
    tdbg = 1'b1;
    run_commit("R7 debug trap");
    check32("R7 literal sw", sw_o, B_DS);
    clear_in();
    set_rec(0, 1, 0, 32'hffff_ffff, 32'hffff_ffff);
    tord = 1'b1; tdbg = 1'b1;
    run_commit("R7 both traps ordinary wins");
    check32("R7 literal priority", sw_o, B_SM | B_DB);

    // R9: idle cycles with busy inputs
    for (int k = 0; k < 20; k++) begin
      for (int i = 0; i < NREC; i++)
        set_rec(i, 1'($urandom), int'($urandom % NREG), $urandom, $urandom);
      tord = 1'($urandom); tdbg = 1'($urandom);
      @(negedge clk);
      check_state("R9 idle hold");
    end

    // R2/R3/R4/R5/R8 sweep
    for (int k = 0; k < 4000; k++) begin
      clear_in();
      for (int i = 0; i < NREC; i++) begin
        vld[i] = ($urandom % 5) != 0;
        tsw[i] = ($urandom % 3) != 0;
        idx[i*IDX_W +: IDX_W] = IDX_W'($urandom % NREG);
        msk[i*W +: W] = rnd_mask();
        val[i*W +: W] = $urandom;
      end
      exempt = ($urandom % 4) == 0;
      tord   = ($urandom % 10) == 0;
      tdbg   = ($urandom % 10) == 0;
      run_commit("R2 R3 R4 R5 R8 sweep");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule